// File: doc/BRIEF.md
# Three-Phase Bridge Gate Control

This block turns host commands into the six gate commands of a three-phase half-bridge motor stage. For each phase the host supplies a high-side enable and a low-side enable. A single shared PWM input chops the active switches. A two-bit chopping mode picks where the chopping happens: on the high-side switches, on the low-side switches, or on both as complementary switching. Inputs from the host pass through multi-flop synchronizers before they reach the gate logic, and the gate commands come from registers.

Four fault flags arrive as synchronous digital inputs: current limit, over-temperature, overvoltage and power-on reset. Any of them forces all six gates off. The shutdown then stays latched until a new PWM period begins with no fault present. The same latched shutdown is set by reset, so the bridge cannot conduct until the host toggles PWM. Each fault also sets a sticky error bit. The host clears these bits with a read strobe once the condition has gone away.

Top module: `bridge_gate_ctrl`

## Requirements
- R1: After reset every gate output and every error bit is 0, and the gates stay off while PWM is held at a constant level; they may turn on only after a rising PWM edge seen after reset.
- R2: In mode 2'b00 (high-side chopping), a phase with only its high enable set drives high = PWM and low = 0; a phase with only its low enable set drives high = 0 and low = 1.
- R3: In mode 2'b01 (low-side chopping), a phase with only its high enable set drives high = 1 and low = 0; a phase with only its low enable set drives high = 0 and low = PWM.
- R4: In mode 2'b10 (complementary), a phase with only its high enable set drives high = PWM and low = NOT PWM; a phase with only its low enable set drives high = 0 and low = 1.
- R5: Mode 2'b11 drives every gate output to 0, and so does a phase with neither enable set, in any mode.
- R6: A phase with both enables set drives both of its gates to 0.
- R7: No phase ever has its high and low gate outputs at 1 in the same cycle.
- R8: While any fault input is 1, every gate output is 0 from the next clock edge on. After the fault input returns to 0, the gates stay off until the next rising edge of the synchronized PWM.
- R9: A rising PWM edge releases the latched shutdown only if all four fault inputs are 0 in that cycle. An edge taken while a fault is present leaves the gates off.
- R10: The error register bits are current limit at bit 0, over-temperature at bit 1, overvoltage at bit 2 and power-on reset at bit 3. A bit is set on the edge after its fault input is 1 and stays set. It clears on the edge after a read strobe only if its fault input is 0 in that cycle.
- R11: A change on an enable, mode or PWM input reaches the gate outputs on the third rising clock edge after it is applied (two synchronizer stages plus the output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_en_i | input | NUM_PHASES | High-side enable per phase |
| ls_en_i | input | NUM_PHASES | Low-side enable per phase |
| pwm_i | input | 1 | Shared PWM chopping input |
| mode_i | input | 2 | Chopping mode select |
| flt_ilim_i | input | 1 | Current-limit fault flag |
| flt_otemp_i | input | 1 | Over-temperature fault flag |
| flt_ovolt_i | input | 1 | Overvoltage fault flag |
| flt_por_i | input | 1 | Power-on-reset fault flag |
| err_rd_i | input | 1 | Host read strobe that clears inactive error bits |
| gate_hi_o | output | NUM_PHASES | High-side gate command per phase |
| gate_lo_o | output | NUM_PHASES | Low-side gate command per phase |
| err_o | output | 4 | Sticky error register |

## Verification
The bench builds the block with its defaults: three phases and two synchronizer stages. With those values the whole input space of the gate logic is small enough to sweep. Every one of the 64 enable combinations is applied in all four modes at both PWM levels, and each result is compared against a truth table computed in the bench. Each of the four fault flags then goes through a full cycle: trip, an edge taken while the fault is still present, release, and clearing the error bit. A separate step times the exact clock edge at which a new enable reaches the gates.

// File: rtl/bgc_pkg.sv
package bgc_pkg;

   typedef enum logic [1:0] {
      MODE_HI_CHOP = 2'b00,
      MODE_LO_CHOP = 2'b01,
      MODE_COMP    = 2'b10,
      MODE_OFF     = 2'b11
   } chop_mode_e;

   localparam int FLT_W     = 4;
   localparam int FLT_ILIM  = 0;
   localparam int FLT_OTEMP = 1;
   localparam int FLT_OVOLT = 2;
   localparam int FLT_POR   = 3;

endpackage

// File: rtl/bgc_sync.sv
module bgc_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bgc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/bgc_phase_drv.sv
module bgc_phase_drv
   import bgc_pkg::*;
(
   input  logic       hs_en,
   input  logic       ls_en,
   input  logic       pwm,
   input  chop_mode_e mode,
   output logic       hi,
   output logic       lo
);

   always_comb begin
      hi = 1'b0;
      lo = 1'b0;
      if (hs_en ^ ls_en) begin
         unique case (mode)
            MODE_HI_CHOP: begin
               if (hs_en) hi = pwm;
               else       lo = 1'b1;
            end
            MODE_LO_CHOP: begin
               if (hs_en) hi = 1'b1;
               else       lo = pwm;
            end
            MODE_COMP: begin
               if (hs_en) begin
                  hi = pwm;
                  lo = ~pwm;
               end else begin
                  lo = 1'b1;
               end
            end
            default: begin
               hi = 1'b0;
               lo = 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/bgc_fault_latch.sv
module bgc_fault_latch
   import bgc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [FLT_W-1:0] flt,
   input  logic             pwm_s,
   input  logic             err_rd,
   output logic             block,
   output logic             kill_q,
   output logic             pwm_rise,
   output logic [FLT_W-1:0] err_q
);

   logic pwm_d;
   logic any_flt;
   logic release_ok;

   assign any_flt    = |flt;
   assign pwm_rise   = pwm_s & ~pwm_d;
   assign release_ok = pwm_rise & ~any_flt;
   assign block      = any_flt | (kill_q & ~release_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwm_d  <= 1'b1;
         kill_q <= 1'b1;
         err_q  <= '0;
      end else begin
         pwm_d <= pwm_s;
         if (any_flt)         kill_q <= 1'b1;
         else if (release_ok) kill_q <= 1'b0;
         err_q <= flt | (err_q & ~({FLT_W{err_rd}} & ~flt));
      end
   end

   assert_err_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flt != '0) |=> ((err_q & $past(flt)) == $past(flt)));

   assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !err_rd |=> ((err_q & $past(err_q)) == $past(err_q)));

   assert_release_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (kill_q && any_flt) |=> kill_q);

endmodule

// File: rtl/bridge_gate_ctrl.sv
module bridge_gate_ctrl
   import bgc_pkg::*;
#(
   parameter int NUM_PHASES  = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PHASES-1:0] hs_en_i,
   input  logic [NUM_PHASES-1:0] ls_en_i,
   input  logic                  pwm_i,
   input  logic [1:0]            mode_i,
   input  logic                  flt_ilim_i,
   input  logic                  flt_otemp_i,
   input  logic                  flt_ovolt_i,
   input  logic                  flt_por_i,
   input  logic                  err_rd_i,
   output logic [NUM_PHASES-1:0] gate_hi_o,
   output logic [NUM_PHASES-1:0] gate_lo_o,
   output logic [FLT_W-1:0]      err_o
);

   localparam int SW      = 2*NUM_PHASES + 3;
   localparam int MODE_LSB = 2*NUM_PHASES;
   localparam int PWM_BIT  = SW - 1;

   generate
      if (NUM_PHASES < 1) begin : g_bad_phases
         $error("bridge_gate_ctrl: NUM_PHASES must be at least 1");
      end
   endgenerate

   logic [SW-1:0]         sync_q;
   logic [NUM_PHASES-1:0] hs_s, ls_s;
   logic                  pwm_s;
   chop_mode_e            mode_s;
   logic [NUM_PHASES-1:0] hi_d, lo_d;
   logic [FLT_W-1:0]      flt;
   logic                  block, kill_q, pwm_rise;

   bgc_sync #(
      .W      (SW),
      .STAGES (SYNC_STAGES),
      .RST_VAL(SW'(1) << PWM_BIT)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({pwm_i, mode_i, ls_en_i, hs_en_i}),
      .q    (sync_q)
   );

   assign hs_s   = sync_q[0 +: NUM_PHASES];
   assign ls_s   = sync_q[NUM_PHASES +: NUM_PHASES];
   assign mode_s = chop_mode_e'(sync_q[MODE_LSB +: 2]);
   assign pwm_s  = sync_q[PWM_BIT];

   assign flt[FLT_ILIM]  = flt_ilim_i;
   assign flt[FLT_OTEMP] = flt_otemp_i;
   assign flt[FLT_OVOLT] = flt_ovolt_i;
   assign flt[FLT_POR]   = flt_por_i;

   bgc_fault_latch u_flt (
      .clk     (clk),
      .rst_n   (rst_n),
      .flt     (flt),
      .pwm_s   (pwm_s),
      .err_rd  (err_rd_i),
      .block   (block),
      .kill_q  (kill_q),
      .pwm_rise(pwm_rise),
      .err_q   (err_o)
   );

   generate
      for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
         bgc_phase_drv u_drv (
            .hs_en(hs_s[p]),
            .ls_en(ls_s[p]),
            .pwm  (pwm_s),
            .mode (mode_s),
            .hi   (hi_d[p]),
            .lo   (lo_d[p])
         );

         assert_invalid_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (hs_s[p] && ls_s[p]) |=> (!gate_hi_o[p] && !gate_lo_o[p]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_hi_o <= '0;
         gate_lo_o <= '0;
      end else if (block) begin
         gate_hi_o <= '0;
         gate_lo_o <= '0;
      end else begin
         gate_hi_o <= hi_d;
         gate_lo_o <= lo_d;
      end
   end

   assert_no_shoot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((gate_hi_o & gate_lo_o) == '0));

   assert_fault_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flt != '0) |=> (gate_hi_o == '0 && gate_lo_o == '0));

   assert_latched_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (kill_q && !pwm_rise) |=> (gate_hi_o == '0 && gate_lo_o == '0));

   assert_mode_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_s == MODE_OFF) |=> (gate_hi_o == '0 && gate_lo_o == '0));

endmodule

// File: tb/bridge_gate_ctrl_test.sv
module bridge_gate_ctrl_test;

   localparam int NP = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] hs_en_i = '0, ls_en_i = '0;
   logic          pwm_i = 1'b1;
   logic [1:0]    mode_i = 2'b00;
   logic          flt_ilim_i = 0, flt_otemp_i = 0, flt_ovolt_i = 0, flt_por_i = 0;
   logic          err_rd_i = 0;
   logic [NP-1:0] gate_hi_o, gate_lo_o;
   logic [3:0]    err_o;

   int checks = 0;
   int fails  = 0;

   always #10ns clk = ~clk;

   bridge_gate_ctrl #(.NUM_PHASES(NP), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .hs_en_i(hs_en_i), .ls_en_i(ls_en_i),
      .pwm_i(pwm_i), .mode_i(mode_i), .flt_ilim_i(flt_ilim_i),
      .flt_otemp_i(flt_otemp_i), .flt_ovolt_i(flt_ovolt_i), .flt_por_i(flt_por_i),
      .err_rd_i(err_rd_i), .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o), .err_o(err_o)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // expected {hi,lo} for one phase
   function automatic logic [1:0] model(input logic h, input logic l, input logic p,
                                        input logic [1:0] m);
      if (h == l || m == 2'b11) return 2'b00;
      case (m)
         2'b00:   return h ? {p, 1'b0} : 2'b01;
         2'b01:   return h ? 2'b10 : {1'b0, p};
         default: return h ? {p, ~p} : 2'b01;
      endcase
   endfunction

   function automatic string tag(input logic [1:0] m, input int e);
      for (int i = 0; i < NP; i++) if (e[2*i] && e[2*i+1]) return "R6";
      case (m)
         2'b00: return "R2";
         2'b01: return "R3";
         2'b10: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_flt(input int f, input logic v);
      case (f)
         0: flt_ilim_i  = v;
         1: flt_otemp_i = v;
         2: flt_ovolt_i = v;
         default: flt_por_i = v;
      endcase
   endtask

   task automatic pwm_toggle();
      pwm_i = 1'b0; wait_n(4);
      pwm_i = 1'b1; wait_n(5);
   endtask

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      hs_en_i = 3'b001;
      wait_n(6);
      check("R1 gates off while PWM constant", {gate_hi_o, gate_lo_o}, 8'h00);
      check("R1 err reset", err_o, 8'h00);
      pwm_toggle();
      check("R1 release after PWM edge", {gate_hi_o, gate_lo_o}, {2'b0, 3'b001, 3'b000});

      // exhaustive sweep of the gate truth table
      for (int m = 0; m < 4; m++) begin
         for (int e = 0; e < 64; e++) begin
            for (int p = 0; p < 2; p++) begin
               logic [NP-1:0] eh, el;
               for (int i = 0; i < NP; i++) begin
                  hs_en_i[i] = e[2*i];
                  ls_en_i[i] = e[2*i+1];
               end
               mode_i = m[1:0];
               pwm_i  = p[0];
               wait_n(4);
               for (int i = 0; i < NP; i++) begin
                  logic [1:0] r;
                  r = model(e[2*i], e[2*i+1], p[0], m[1:0]);
                  eh[i] = r[1];
                  el[i] = r[0];
               end
               check(tag(m[1:0], e), {2'b0, gate_hi_o, gate_lo_o}, {2'b0, eh, el});
               check("R7 no shoot-through", {5'b0, gate_hi_o & gate_lo_o}, 8'h00);
            end
         end
      end

      // latency
      mode_i = 2'b00; pwm_i = 1'b1; hs_en_i = '0; ls_en_i = '0;
      wait_n(5);
      hs_en_i = 3'b010;
      wait_n(2);
      check("R11 not yet after two edges", {5'b0, gate_hi_o}, 8'h00);
      wait_n(1);
      check("R11 on third edge", {5'b0, gate_hi_o}, 8'h02);

      // fault sequences, one per flag
      for (int f = 0; f < 4; f++) begin
         hs_en_i = 3'b001; ls_en_i = '0; mode_i = 2'b00; pwm_i = 1'b1;
         wait_n(5);
         check("R8 baseline on", {5'b0, gate_hi_o}, 8'h01);
         set_flt(f, 1'b1);
         wait_n(1);
         check("R8 fault forces off", {gate_hi_o, gate_lo_o}, 8'h00);
         check("R10 error bit set", err_o, 8'(1 << f));
         err_rd_i = 1'b1; wait_n(1); err_rd_i = 1'b0;
         check("R10 read while active keeps bit", err_o, 8'(1 << f));
         pwm_toggle();
         check("R9 edge during fault keeps off", {gate_hi_o, gate_lo_o}, 8'h00);
         set_flt(f, 1'b0);
         wait_n(4);
         check("R8 stays off after fault clears", {gate_hi_o, gate_lo_o}, 8'h00);
         check("R10 sticky after fault clears", err_o, 8'(1 << f));
         err_rd_i = 1'b1; wait_n(1); err_rd_i = 1'b0;
         check("R10 read clears inactive bit", err_o, 8'h00);
         pwm_toggle();
         check("R9 clean edge releases", {5'b0, gate_hi_o}, 8'h01);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(20ns * 150000);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule